// File: doc/BRIEF.md
# Quantized Line Feed-Forward Level Tracker

This block follows the peak of a rectified, scaled sinusoidal line voltage. Each valid strobe brings in one digitized sample. From the peak the block selects one of eight discrete feed-forward levels. A power-factor control loop uses that level in place of a filtered RMS measurement. Alongside the level the block outputs a fixed-point squared-volt coefficient.

The level rises as soon as the running half-cycle peak crosses a rising threshold, even in the middle of a half-cycle. The level falls only at a timed zero-crossing, and the test then uses falling thresholds set at 95% of the rising ones. This hysteresis stops the level from chattering at a boundary. A hold input freezes the level. Peak capture and zero-crossing detection keep running while the level is frozen.

Top module: `qff_tracker`

## Requirements
- R1: After a synchronous reset the level is 1, the coefficient is 1630, both pulses are low and the running peak is zero.
- R2: The level is encoded as the integer 1..8. Level L (L = 2..8) has a rising threshold of 1000, 1200, 1400, 1650, 1950, 2250 or 2600 mV respectively. On a valid, unheld sample, the running peak is updated as the maximum of the stored peak and the sample. If that updated peak meets a rising threshold above the current level, the level jumps directly to the highest level whose rising threshold is met. The new level is visible in the cycle after the sample.
- R3: The falling threshold of level L is floor(95% of its rising threshold): 950, 1140, 1330, 1567, 1852, 2137 and 2470 mV. At a zero-crossing the stored peak is tested against the falling threshold of the current level. If the peak is below it, the level drops to the highest level whose falling threshold the peak still meets (level 1 if none). Otherwise the level is kept.
- R4: A zero-crossing pulse lasts one cycle. It follows the ZC_SAMPLES-th consecutive valid sample below 700 mV, counted after reset or after a sample of 700 mV or more. Only one pulse is issued per low interval. A sample of 700 mV or more restarts the count.
- R5: At a zero-crossing the running peak clears to zero. The next down-step decision therefore depends only on samples taken after that crossing.
- R6: The coefficient is unsigned Q4.12, rounded to the nearest code. Levels 1..8 give 1630, 2458, 3437, 4735, 6570, 9007, 11969 and 15798.
- R7: The level-change output is high for exactly the cycles in which the level differs from its value one cycle earlier.
- R8: While hold is high the level does not change. Peak capture and zero-crossing detection continue. The first valid sample after hold is released applies any up-step the captured peak calls for.
- R9: Cycles with the valid strobe low change neither the level, the peak nor the zero-crossing count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_mv | input | SAMPLE_W | Unsigned sample, 1 mV per LSB |
| hold | input | 1 | Freezes the level |
| level | output | 4 | Feed-forward level, 1..8 |
| coef | output | 16 | Level coefficient, unsigned Q4.12 |
| level_chg | output | 1 | One-cycle pulse when the level changes |
| zc_pulse | output | 1 | One-cycle zero-crossing pulse |

## Verification
The bench builds the block with ZC_SAMPLES = 8 and the default 12-bit sample width. With this short window a triangular half-cycle of about 40 samples is enough to reach a zero-crossing. Hundreds of down-step decisions, low intervals shorter than the window and hold windows therefore fit in a short run. The full 12-bit range still reaches past the top threshold and lets directed samples land exactly on each rising and falling boundary.

// File: rtl/qff_pkg.sv
package qff_pkg;

    typedef logic [15:0] mv_t;
    typedef logic [3:0]  level_t;
    typedef logic [15:0] coef_t;

    localparam int NUM_LEVELS = 8;
    localparam int NUM_THR    = NUM_LEVELS - 1;
    localparam int ZC_MV      = 700;

    typedef struct packed {
        level_t level;
        logic   chg;
    } lvl_state_t;

    // rising threshold that admits level idx+2
    function automatic mv_t rise_mv(input int idx);
        case (idx)
            0:       return mv_t'(1000);
            1:       return mv_t'(1200);
            2:       return mv_t'(1400);
            3:       return mv_t'(1650);
            4:       return mv_t'(1950);
            5:       return mv_t'(2250);
            default: return mv_t'(2600);
        endcase
    endfunction

    function automatic mv_t fall_mv(input int idx);
        return mv_t'((int'(rise_mv(idx)) * 95) / 100);
    endfunction

    function automatic coef_t q412(input int milli);
        return coef_t'((milli * 4096 + 500) / 1000);
    endfunction

    function automatic coef_t coef_of(input level_t lv);
        case (lv)
            4'd1:    return q412(398);
            4'd2:    return q412(600);
            4'd3:    return q412(839);
            4'd4:    return q412(1156);
            4'd5:    return q412(1604);
            4'd6:    return q412(2199);
            4'd7:    return q412(2922);
            default: return q412(3857);
        endcase
    endfunction

endpackage

// File: rtl/qff_peak_hold.sv
module qff_peak_hold
    import qff_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  mv_t  sample,
    input  logic clear,
    output mv_t  peak_cur,
    output mv_t  peak_new
);
    mv_t peak_q;

    always_comb begin
        peak_new = peak_q;
        if (valid && sample > peak_q) peak_new = sample;
    end

    always_ff @(posedge clk) begin
        if (rst)        peak_q <= '0;
        else if (clear) peak_q <= '0;
        else            peak_q <= peak_new;
    end

    assign peak_cur = peak_q;
endmodule

// File: rtl/qff_zero_detect.sv
module qff_zero_detect
    import qff_pkg::*;
#(
    parameter int ZC_SAMPLES = 50
)(
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  mv_t  sample,
    output logic zc_now,
    output logic zc_q
);
    localparam int CNT_W = $clog2(ZC_SAMPLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             low;

    assign low    = sample < mv_t'(ZC_MV);
    assign zc_now = valid && low && armed_q &&
                    (cnt_q + CNT_W'(1) == CNT_W'(ZC_SAMPLES));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
            zc_q    <= 1'b0;
        end else begin
            zc_q <= zc_now;
            if (valid) begin
                if (!low) begin
                    cnt_q   <= '0;
                    armed_q <= 1'b1;
                end else if (zc_now) begin
                    cnt_q   <= '0;
                    armed_q <= 1'b0;
                end else if (armed_q) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/qff_level_fsm.sv
module qff_level_fsm
    import qff_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic       hold,
    input  logic       zc_now,
    input  mv_t        peak_cur,
    input  mv_t        peak_new,
    output lvl_state_t st
);
    logic [NUM_THR-1:0] rise_hit;
    logic [NUM_THR-1:0] fall_hit;
    level_t up_lvl, dn_lvl, nxt;
    lvl_state_t st_q;

    for (genvar g = 0; g < NUM_THR; g++) begin : g_cmp
        assign rise_hit[g] = peak_new >= rise_mv(g);
        assign fall_hit[g] = peak_cur >= fall_mv(g);
    end

    always_comb begin
        up_lvl = level_t'(1);
        dn_lvl = level_t'(1);
        for (int i = 0; i < NUM_THR; i++) begin
            if (rise_hit[i]) up_lvl = level_t'(i + 2);
            if (fall_hit[i]) dn_lvl = level_t'(i + 2);
        end
    end

    always_comb begin
        nxt = st_q.level;
        if (valid && !hold) begin
            if (up_lvl > st_q.level)               nxt = up_lvl;
            else if (zc_now && dn_lvl < st_q.level) nxt = dn_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.level <= level_t'(1);
            st_q.chg   <= 1'b0;
        end else begin
            st_q.level <= nxt;
            st_q.chg   <= nxt != st_q.level;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/qff_tracker.sv
module qff_tracker
    import qff_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int ZC_SAMPLES = 50
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_mv,
    input  logic                hold,
    output logic [3:0]          level,
    output logic [15:0]         coef,
    output logic                level_chg,
    output logic                zc_pulse
);
    mv_t        sample;
    mv_t        peak_cur, peak_new;
    logic       zc_now, zc_q;
    lvl_state_t st;

    assign sample = mv_t'(smp_mv);

    qff_zero_detect #(.ZC_SAMPLES(ZC_SAMPLES)) u_zc (
        .clk(clk), .rst(rst), .valid(smp_valid), .sample(sample),
        .zc_now(zc_now), .zc_q(zc_q)
    );

    qff_peak_hold u_peak (
        .clk(clk), .rst(rst), .valid(smp_valid), .sample(sample),
        .clear(zc_now), .peak_cur(peak_cur), .peak_new(peak_new)
    );

    qff_level_fsm u_lvl (
        .clk(clk), .rst(rst), .valid(smp_valid), .hold(hold),
        .zc_now(zc_now), .peak_cur(peak_cur), .peak_new(peak_new), .st(st)
    );

    assign level     = st.level;
    assign coef      = coef_of(st.level);
    assign level_chg = st.chg;
    assign zc_pulse  = zc_q;
endmodule

// File: rtl/qff_tracker_chk.sv
module qff_tracker_chk (
    input logic        clk,
    input logic        rst,
    input logic        smp_valid,
    input logic        hold,
    input logic [3:0]  level,
    input logic        level_chg,
    input logic        zc_pulse
);
    // R2
    level_range_chk: assert property (@(posedge clk) disable iff (rst)
        level >= 4'd1 && level <= 4'd8);

    // R8
    level_move_chk: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |-> ($past(smp_valid) && !$past(hold)));

    // R3
    level_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (level < $past(level)) |-> zc_pulse);

    // R7
    chg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        level_chg |-> (level != $past(level)));

    // R4
    zc_single_chk: assert property (@(posedge clk) disable iff (rst)
        zc_pulse |=> !zc_pulse);
endmodule

bind qff_tracker qff_tracker_chk u_chk (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .hold(hold),
    .level(level), .level_chg(level_chg), .zc_pulse(zc_pulse)
);

// File: tb/qff_tracker_test.sv
module qff_tracker_test;
    localparam int ZCN = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_mv = '0;
    logic        hold = 1'b0;
    logic [3:0]  level;
    logic [15:0] coef;
    logic        level_chg, zc_pulse;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // model state
    int m_level = 1, m_peak = 0, m_cnt = 0;
    bit m_armed = 1, m_chg = 0, m_zc = 0;

    always #2 clk = ~clk;

    qff_tracker #(.SAMPLE_W(12), .ZC_SAMPLES(ZCN)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_mv(smp_mv),
        .hold(hold), .level(level), .coef(coef),
        .level_chg(level_chg), .zc_pulse(zc_pulse)
    );

    function automatic int rise_t(int i);
        int t[7] = '{1000, 1200, 1400, 1650, 1950, 2250, 2600};
        return t[i];
    endfunction
    function automatic int fall_t(int i);
        int t[7] = '{950, 1140, 1330, 1567, 1852, 2137, 2470};
        return t[i];
    endfunction
    function automatic int exp_coef(int l);
        int t[8] = '{1630, 2458, 3437, 4735, 6570, 9007, 11969, 15798};
        return t[l-1];
    endfunction

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R2/R3/R8/R9 level", level, m_level);
        chk("R6 coef", coef, exp_coef(m_level));
        chk("R7 level_chg", level_chg, m_chg);
        chk("R4/R5 zc_pulse", zc_pulse, m_zc);
    endtask

    // one cycle: check outputs, then drive and advance model
    task automatic step(bit v, int s, bit h);
        int np, up, dn, nl;
        bit zc;
        @(negedge clk);
        compare();
        smp_valid = v; smp_mv = 12'(s); hold = h;
        nl = m_level; zc = 0;
        if (v) begin
            np = (s > m_peak) ? s : m_peak;
            if (s >= 700) begin m_cnt = 0; m_armed = 1; end
            else if (m_armed) begin
                if (m_cnt + 1 == ZCN) begin zc = 1; m_armed = 0; m_cnt = 0; end
                else m_cnt++;
            end
            up = 1; dn = 1;
            for (int i = 0; i < 7; i++) begin
                if (np >= rise_t(i)) up = i + 2;
                if (m_peak >= fall_t(i)) dn = i + 2;
            end
            if (!h) begin
                if (up > m_level) nl = up;
                else if (zc && dn < m_level) nl = dn;
            end
            m_peak = zc ? 0 : np;
        end
        m_chg = (nl != m_level);
        m_level = nl;
        m_zc = zc;
    endtask

    task automatic low_run(int n, bit h);
        for (int k = 0; k < n; k++) step(1, 100, h);
    endtask

    task automatic half_cycle(int amp, int len, bit h);
        for (int k = 0; k <= len; k++) begin
            int m = (k < len - k) ? k : len - k;
            if ($urandom_range(0, 9) == 0) step(0, 4000, h);   // R9 ignored
            step(1, amp * m * 2 / len, h);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        chk("R1 level", level, 1);
        chk("R1 coef", coef, 1630);
        chk("R1 pulses", {level_chg, zc_pulse}, 0);

        // R2 boundary 999 / 1000, then direct jump to 8
        step(1, 999, 0);
        step(1, 1000, 0);
        step(1, 800, 0);
        step(1, 2600, 0);
        step(1, 800, 0);
        // R4 short low interval, then full interval, then stay low
        low_run(ZCN - 1, 0);
        step(1, 800, 0);
        low_run(ZCN + 5, 0);
        // R3 peak at falling threshold keeps level 8
        half_cycle(2470, 40, 0);
        low_run(ZCN + 1, 0);
        // R3 one below drops to 7
        half_cycle(2469, 40, 0);
        low_run(ZCN + 1, 0);
        // R3/R5 small peak drops to 1
        half_cycle(720, 40, 0);
        low_run(ZCN + 1, 0);
        // R8 hold: peak captured but level frozen, then released
        half_cycle(2000, 40, 1);
        step(1, 300, 0);
        low_run(ZCN + 1, 0);
        // R9 invalid cycles with large value
        step(0, 4000, 0);
        step(0, 4000, 0);

        // constrained random half-cycles
        for (int n = 0; n < 400; n++) begin
            half_cycle($urandom_range(300, 3300), $urandom_range(20, 60),
                       $urandom_range(0, 9) == 0);
            low_run($urandom_range(ZCN - 2, ZCN + 4), $urandom_range(0, 9) == 0);
        end
        @(negedge clk);
        compare();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule